// File: doc/BRIEF.md
# Scan Shift Transition Power Estimator

This block estimates the switching activity caused by loading a test vector into a scan chain and unloading a captured response from it. Given the vector to be loaded and the response to be unloaded, it reports a position-weighted shift-in transition count, a position-weighted shift-out transition count, their sum, and the number of flip-flops that toggle at capture. Capture toggles are the bits in which the loaded vector and the response differ.

Each adjacent-bit change in a vector costs as many flip-flop toggles as the number of chain cells it sweeps through while shifting. The block can find these totals in one of two ways, chosen per run. The closed-form mode adds up position weights in a single step. The emulation mode shifts shadow copies of the chain one cell per clock and counts the cells that really change state. Both modes must give identical results.

Vector bit 0 is the cell nearest scan-in and bit N-1 is the cell nearest scan-out. The first bit shifted in is bit N-1. During unload, the vacated cells keep the value of bit 0.

Top module: `scan_shift_power`

## Requirements
- R1: After reset, `done` is low and all four count outputs are zero.
- R2: The shift-in count adds a weight of i+1 for every index i (0 to N-2) where `load_vec[i]` differs from `load_vec[i+1]`.
- R3: The shift-out count adds a weight of N-1-i for every index i (0 to N-2) where `resp_vec[i]` differs from `resp_vec[i+1]`.
- R4: `total_cnt` equals the shift-in count plus the shift-out count.
- R5: `cap_cnt` is the number of bit positions in which `load_vec` and `resp_vec` differ.
- R6: With `use_shift` low when a start is accepted, `done` is high after the second rising edge that follows, counting the accepting edge as the first.
- R7: With `use_shift` high when a start is accepted, the counts come from N clocks of emulated shifting and equal the closed-form values. `done` rises after the N+1-th rising edge, counting the accepting edge as the first.
- R8: A `start` raised while a computation is in progress has no effect on that computation's results.
- R9: Accepting a start drops `done` at that edge. Once `done` is high, it and every count stay unchanged until the next accepted start, whatever the vector inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a computation; sampled only when idle |
| use_shift | input | 1 | 0 selects the closed-form mode, 1 selects the emulation mode |
| load_vec | input | N | Vector to be shifted in (bit 0 nearest scan-in) |
| resp_vec | input | N | Captured response to be shifted out |
| done | output | 1 | Results valid |
| shin_cnt | output | SW | Weighted shift-in transitions |
| shout_cnt | output | SW | Weighted shift-out transitions |
| total_cnt | output | TW | Sum of shift-in and shift-out counts |
| cap_cnt | output | CW | Capture toggles |

## Verification
The hardest condition to reach from the ports is a second start that arrives during an emulation run, when the shadow chains are partly shifted. The stimulus raises `start` with different vectors on the cycle after acceptance. It then checks that the counts still match the first vectors. Every vector pair is also run in both modes, so a mistake in the per-position weighting shows up as a mismatch between the closed-form sum and the counted toggles. The vectors include alternating patterns that maximise both weights, and single edges at the two ends of the chain.

// File: rtl/scan_shift_power.sv
module scan_shift_power #(
  parameter int N = 16
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     start,
  input  logic                                     use_shift,
  input  logic [N-1:0]                             load_vec,
  input  logic [N-1:0]                             resp_vec,
  output logic                                     done,
  output logic [$clog2(N*(N-1)/2+1)-1:0]           shin_cnt,
  output logic [$clog2(N*(N-1)/2+1)-1:0]           shout_cnt,
  output logic [$clog2(N*(N-1)+1)-1:0]             total_cnt,
  output logic [$clog2(N+1)-1:0]                   cap_cnt
);
  localparam int MAXW = N * (N - 1) / 2;
  localparam int SW   = $clog2(MAXW + 1);
  localparam int TW   = $clog2(2 * MAXW + 1);
  localparam int CW   = $clog2(N + 1);
  localparam int STW  = (N > 2) ? $clog2(N) : 1;

  logic           busy, mode_q;
  logic [STW-1:0] step;
  logic [N-1:0]   src, in_ch, out_ch;
  logic [N-1:0]   in_nx, out_nx;
  logic [SW-1:0]  cf_in, cf_out;
  logic [CW-1:0]  cap_c, d_in, d_out;

  function automatic logic [CW-1:0] popc(input logic [N-1:0] v);
    logic [CW-1:0] c;
    c = '0;
    for (int j = 0; j < N; j++) c = c + CW'(v[j]);
    return c;
  endfunction

  always_comb begin
    cf_in  = '0;
    cf_out = '0;
    for (int i = 0; i < N - 1; i++) begin
      if (load_vec[i] != load_vec[i+1]) cf_in  = cf_in  + SW'(i + 1);
      if (resp_vec[i] != resp_vec[i+1]) cf_out = cf_out + SW'(N - 1 - i);
    end
  end

  assign cap_c  = popc(load_vec ^ resp_vec);
  assign in_nx  = {in_ch[N-2:0], src[N-1]};
  assign out_nx = {out_ch[N-2:0], out_ch[0]};
  assign d_in   = popc(in_nx ^ in_ch);
  assign d_out  = popc(out_nx ^ out_ch);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      mode_q    <= 1'b0;
      step      <= '0;
      src       <= '0;
      in_ch     <= '0;
      out_ch    <= '0;
      shin_cnt  <= '0;
      shout_cnt <= '0;
      total_cnt <= '0;
      cap_cnt   <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      done    <= 1'b0;
      mode_q  <= use_shift;
      step    <= '0;
      src     <= load_vec;
      in_ch   <= {N{load_vec[N-1]}};
      out_ch  <= resp_vec;
      cap_cnt <= cap_c;
      if (use_shift) begin
        shin_cnt  <= '0;
        shout_cnt <= '0;
        total_cnt <= '0;
      end else begin
        shin_cnt  <= cf_in;
        shout_cnt <= cf_out;
        total_cnt <= TW'(cf_in) + TW'(cf_out);
      end
    end else if (busy) begin
      if (!mode_q) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        in_ch     <= in_nx;
        out_ch    <= out_nx;
        src       <= src << 1;
        shin_cnt  <= shin_cnt + SW'(d_in);
        shout_cnt <= shout_cnt + SW'(d_out);
        total_cnt <= total_cnt + TW'(d_in) + TW'(d_out);
        step      <= step + 1'b1;
        if (step == STW'(N - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(shin_cnt) && $stable(shout_cnt) && $stable(cap_cnt)));

  // R8
  ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(cap_cnt));

  // R6
  closed_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !use_shift) |=> (!done ##1 done));

  // R7
  emul_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && use_shift) |=> !done);

  // R5
  cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cap_cnt <= CW'(N)));

  // R2
  shin_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (shin_cnt <= SW'(MAXW) && shout_cnt <= SW'(MAXW)));
endmodule

// File: tb/scan_shift_power_tb.sv
module scan_shift_power_tb;
  localparam int N = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, use_shift = 1'b0;
  logic [N-1:0] load_vec = '0, resp_vec = '0;
  logic done;
  logic [$clog2(N*(N-1)/2+1)-1:0] shin_cnt, shout_cnt;
  logic [$clog2(N*(N-1)+1)-1:0]   total_cnt;
  logic [$clog2(N+1)-1:0]         cap_cnt;

  int nchk = 0, nerr = 0;
  logic done_d = 1'b0;

  typedef struct { int si; int so; int cp; } exp_t;
  exp_t q[$];
  exp_t last;

  scan_shift_power #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .use_shift(use_shift),
    .load_vec(load_vec), .resp_vec(resp_vec), .done(done),
    .shin_cnt(shin_cnt), .shout_cnt(shout_cnt), .total_cnt(total_cnt), .cap_cnt(cap_cnt));

  always #10 clk = ~clk;

  task automatic chk(input string r, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", r, act, exp);
    end
  endtask

  // Cycle-by-cycle shifting model: counts cells that change state
  function automatic void model(input logic [N-1:0] ld, input logic [N-1:0] rs,
                                output int si, output int so, output int cp);
    logic [N-1:0] ch, nx;
    si = 0; so = 0; cp = 0;
    ch = {N{ld[N-1]}};
    for (int k = 0; k < N; k++) begin
      nx = {ch[N-2:0], ld[N-1-k]};
      for (int j = 0; j < N; j++) if (nx[j] != ch[j]) si++;
      ch = nx;
    end
    ch = rs;
    for (int k = 0; k < N; k++) begin
      nx = {ch[N-2:0], ch[0]};
      for (int j = 0; j < N; j++) if (nx[j] != ch[j]) so++;
      ch = nx;
    end
    for (int j = 0; j < N; j++) if (ld[j] != rs[j]) cp++;
  endfunction

  // Monitor: pops an expectation on every rising done
  always @(negedge clk) begin
    if (rst_n && done && !done_d) begin
      if (q.size() == 0) chk("R9 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk("R2 shift-in", int'(shin_cnt), e.si);
        chk("R3 shift-out", int'(shout_cnt), e.so);
        chk("R4 total", int'(total_cnt), e.si + e.so);
        chk("R5 capture", int'(cap_cnt), e.cp);
      end
    end
    done_d <= done;
  end

  task automatic run(input logic [N-1:0] ld, input logic [N-1:0] rs,
                     input logic m, input bit inject, input bit hold);
    exp_t e;
    int lat;
    model(ld, rs, e.si, e.so, e.cp);
    q.push_back(e);
    last = e;
    @(negedge clk);
    load_vec = ld; resp_vec = rs; use_shift = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 done drops on start", int'(done), 0);
    lat = 1;
    if (inject) begin
      // R8: start with other vectors while busy
      load_vec = ~ld; resp_vec = ld; use_shift = ~m; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    while (!done && lat < 4 * N) begin
      @(negedge clk);
      lat++;
    end
    if (m) chk("R7 emulation latency", lat, N + 1);
    else   chk("R6 closed-form latency", lat, 2);
    @(negedge clk);
    if (hold) begin
      for (int k = 0; k < 4; k++) begin
        load_vec = $urandom; resp_vec = $urandom; use_shift = ~use_shift;
        @(negedge clk);
      end
      chk("R9 done held", int'(done), 1);
      chk("R9 shift-in held", int'(shin_cnt), last.si);
      chk("R9 shift-out held", int'(shout_cnt), last.so);
      chk("R9 capture held", int'(cap_cnt), last.cp);
    end
  endtask

  initial begin
    int si, so, cp;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 done reset", int'(done), 0);
    chk("R1 shin reset", int'(shin_cnt), 0);
    chk("R1 shout reset", int'(shout_cnt), 0);
    chk("R1 total reset", int'(total_cnt), 0);
    chk("R1 cap reset", int'(cap_cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Hand values for the weighting rules (R2, R3, R5)
    model(16'h5555, 16'h5555, si, so, cp);
    chk("R2 alternating hand value", si, 120);
    chk("R3 alternating hand value", so, 120);
    model(16'h0001, 16'h8000, si, so, cp);
    chk("R2 edge at scan-in end", si, 1);
    chk("R3 edge at scan-out end", so, 1);
    chk("R5 hand value", cp, 2);

    for (int m = 0; m < 2; m++) begin
      run(16'h0000, 16'h0000, m[0], 0, 1);
      run(16'h5555, 16'hAAAA, m[0], 0, 0);
      run(16'h0001, 16'h8000, m[0], 0, 0);
      run(16'h8000, 16'h0001, m[0], 0, 0);
      run(16'hFFFF, 16'h0000, m[0], 0, 1);
      run(16'h00FF, 16'h0FF0, m[0], 1, 0);
    end
    for (int r = 0; r < 10; r++) begin
      logic [N-1:0] a, b;
      a = $urandom; b = $urandom;
      run(a, b, 1'b0, (r % 3) == 0, 0);
      run(a, b, 1'b1, (r % 3) == 1, (r % 4) == 0);
    end
    repeat (4) @(negedge clk);
    chk("R9 queue drained", q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
    $finish;
  end

  initial begin
    #(20 * 100000);
    nchk++; nerr++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
    $finish;
  end
endmodule